// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block moves a processor core into and out of a dedicated debug mode. It holds the core's status register. When a debug request is accepted, it marks the core as being in debug mode and switches the execution-mode field to the exception context. It then emits a one-cycle redirect strobe that carries the fixed address of the debug handler. On the same clock edge it copies the interrupted program counter and the status register in force before entry into a private pair of return registers. No stack traffic is needed.

While the debug flag is set, software may rewrite the status register freely, including the mode field, without losing privilege. A return strobe in debug mode copies the saved status back into the status register. It also raises a one-cycle resume strobe, and the saved program counter stays visible for refetch. Instruction decode, pipeline flush and memory access are handled elsewhere. They reach this block only as strobes.

The block has an asynchronous active-low reset. That reset is expected to be released in step with the clock by logic upstream.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `sr_o` equals the reset value (default 16'h0001), `redirect_o` and `resume_o` are low, and `ret_pc_o` and `ret_sr_o` are zero.
- R2: A request on `dbg_req_i` is accepted when debug flag bit 6 and mask bit 5 of `sr_o` are both clear. On the next edge `redirect_o` rises and `target_pc_o` carries the handler address (default 32'h8000_0100).
- R3: With mask bit 5 set, a request is ignored: `redirect_o` stays low and `sr_o` is unchanged.
- R4: Entry sets bit 6 of `sr_o` and writes the exception code 3'b110 into the mode field, bits 2:0. All other bits are kept.
- R5: On the entry edge, `ret_pc_o` takes `pc_i` and `ret_sr_o` takes the value `sr_o` held before entry.
- R6: `redirect_o` is high for exactly one cycle, even when the request is held.
- R7: A request while bit 6 is set is ignored. No redirect is raised and `ret_pc_o` and `ret_sr_o` keep their values.
- R8: In debug mode, a write (`sr_wr_i`) replaces every bit of `sr_o` with `sr_wdata_i`, mode field included, except bit 6, which stays set.
- R9: Outside debug mode, a write leaves bit 6 clear. In user mode (mode field 3'b000) the write also leaves the mode field unchanged. In any other mode the write replaces every bit except bit 6.
- R10: `dret_i` in debug mode loads `ret_sr_o` into `sr_o`, which clears bit 6. It also raises `resume_o` for exactly one cycle, with `ret_pc_o` as the resume address.
- R11: `dret_i` outside debug mode has no effect: `resume_o` stays low and `sr_o` is unchanged.
- R12: Priority holds when strobes coincide. An accepted request wins over a write. In debug mode, `dret_i` wins over both a write and a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req_i | input | 1 | Debug request |
| pc_i | input | PC_W | Program counter of the instruction being interrupted |
| sr_wr_i | input | 1 | Software status register write strobe |
| sr_wdata_i | input | SR_W | Status register write data |
| dret_i | input | 1 | Return-from-debug strobe |
| redirect_o | output | 1 | One-cycle fetch redirect to the debug handler |
| target_pc_o | output | PC_W | Debug handler address |
| sr_o | output | SR_W | Current status register |
| resume_o | output | 1 | One-cycle return strobe |
| ret_pc_o | output | PC_W | Saved program counter (resume address) |
| ret_sr_o | output | SR_W | Saved status register |

## Verification
Every result of this block is registered once. The redirect, resume, status register and saved registers therefore all change on the first rising edge after the stimulus is applied. The bench drives each stimulus on a falling edge, waits for one rising edge, and samples on the falling edge after it. This places every check exactly one edge after its cause. Holding a request across two edges checks that the second edge brings no further redirect and no new capture.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,
    EV_ENTER  = 2'd1,
    EV_RETURN = 2'd2,
    EV_SWWR   = 2'd3
  } dbg_ev_e;
endpackage

// File: rtl/dbg_event_decode.sv
module dbg_event_decode
  import dbg_pkg::*;
(
  input  logic    in_dbg_i,
  input  logic    mask_i,
  input  logic    dbg_req_i,
  input  logic    dret_i,
  input  logic    sr_wr_i,
  output dbg_ev_e ev_o
);
  // One event per cycle; entry beats a write, return beats everything in debug.
  always_comb begin
    ev_o = EV_IDLE;
    if (in_dbg_i) begin
      if (dret_i)       ev_o = EV_RETURN;
      else if (sr_wr_i) ev_o = EV_SWWR;
    end else begin
      if (dbg_req_i && !mask_i) ev_o = EV_ENTER;
      else if (sr_wr_i)         ev_o = EV_SWWR;
    end
  end
endmodule

// File: rtl/dbg_sr_next.sv
module dbg_sr_next
  import dbg_pkg::*;
#(
  parameter int SR_W      = 16,
  parameter int MODE_LSB  = 0,
  parameter int MODE_W    = 3,
  parameter int DFLAG_BIT = 6,
  parameter logic [MODE_W-1:0] EXC_MODE  = 3'b110,
  parameter logic [MODE_W-1:0] USER_MODE = 3'b000
) (
  input  dbg_ev_e         ev_i,
  input  logic [SR_W-1:0] sr_q_i,
  input  logic [SR_W-1:0] wdata_i,
  input  logic [SR_W-1:0] saved_sr_i,
  output logic [SR_W-1:0] sr_d_o
);
  logic [SR_W-1:0] mode_mask;
  logic [SR_W-1:0] dflag_mask;
  logic [SR_W-1:0] exc_bits;

  for (genvar b = 0; b < SR_W; b++) begin : g_mask
    assign mode_mask[b]  = (b >= MODE_LSB) && (b < MODE_LSB + MODE_W);
    assign dflag_mask[b] = (b == DFLAG_BIT);
  end

  assign exc_bits = SR_W'(EXC_MODE) << MODE_LSB;

  logic in_dbg;
  logic is_user;
  assign in_dbg  = sr_q_i[DFLAG_BIT];
  assign is_user = (sr_q_i[MODE_LSB +: MODE_W] == USER_MODE);

  always_comb begin
    sr_d_o = sr_q_i;
    case (ev_i)
      EV_ENTER:  sr_d_o = (sr_q_i & ~mode_mask) | exc_bits | dflag_mask;
      EV_RETURN: sr_d_o = saved_sr_i;
      EV_SWWR: begin
        if (in_dbg)       sr_d_o = wdata_i | dflag_mask;
        else if (is_user) sr_d_o = (wdata_i & ~mode_mask & ~dflag_mask)
                                   | (sr_q_i & mode_mask);
        else              sr_d_o = wdata_i & ~dflag_mask;
      end
      default:   sr_d_o = sr_q_i;
    endcase
  end
endmodule

// File: rtl/dbg_save_regs.sv
module dbg_save_regs #(
  parameter int PC_W = 32,
  parameter int SR_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [SR_W-1:0] sr_i,
  output logic [PC_W-1:0] pc_q_o,
  output logic [SR_W-1:0] sr_q_o
);
  logic [PC_W-1:0] pc_d;
  logic [SR_W-1:0] sr_d;

  always_comb begin
    pc_d = pc_q_o;
    sr_d = sr_q_o;
    if (cap_i) begin
      pc_d = pc_i;
      sr_d = sr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q_o <= '0;
      sr_q_o <= '0;
    end else begin
      pc_q_o <= pc_d;
      sr_q_o <= sr_d;
    end
  end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int SR_W      = 16,
  parameter int MODE_LSB  = 0,
  parameter int MODE_W    = 3,
  parameter int DMASK_BIT = 5,
  parameter int DFLAG_BIT = 6,
  parameter logic [MODE_W-1:0] EXC_MODE    = 3'b110,
  parameter logic [MODE_W-1:0] USER_MODE   = 3'b000,
  parameter logic [SR_W-1:0]   SR_RESET    = 16'h0001,
  parameter logic [PC_W-1:0]   DBG_HANDLER = 32'h8000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_req_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            sr_wr_i,
  input  logic [SR_W-1:0] sr_wdata_i,
  input  logic            dret_i,
  output logic            redirect_o,
  output logic [PC_W-1:0] target_pc_o,
  output logic [SR_W-1:0] sr_o,
  output logic            resume_o,
  output logic [PC_W-1:0] ret_pc_o,
  output logic [SR_W-1:0] ret_sr_o
);
  // Debug flag is always clear coming out of reset.
  localparam logic [SR_W-1:0] SR_RST_CLEAN = SR_RESET & ~(SR_W'(1) << DFLAG_BIT);

  dbg_ev_e         ev;
  logic [SR_W-1:0] sr_q, sr_d;
  logic            redirect_q, redirect_d;
  logic            resume_q, resume_d;

  dbg_event_decode u_dec (
    .in_dbg_i  (sr_q[DFLAG_BIT]),
    .mask_i    (sr_q[DMASK_BIT]),
    .dbg_req_i (dbg_req_i),
    .dret_i    (dret_i),
    .sr_wr_i   (sr_wr_i),
    .ev_o      (ev)
  );

  dbg_sr_next #(
    .SR_W(SR_W), .MODE_LSB(MODE_LSB), .MODE_W(MODE_W),
    .DFLAG_BIT(DFLAG_BIT), .EXC_MODE(EXC_MODE), .USER_MODE(USER_MODE)
  ) u_srn (
    .ev_i       (ev),
    .sr_q_i     (sr_q),
    .wdata_i    (sr_wdata_i),
    .saved_sr_i (ret_sr_o),
    .sr_d_o     (sr_d)
  );

  dbg_save_regs #(.PC_W(PC_W), .SR_W(SR_W)) u_save (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (ev == EV_ENTER),
    .pc_i   (pc_i),
    .sr_i   (sr_q),
    .pc_q_o (ret_pc_o),
    .sr_q_o (ret_sr_o)
  );

  always_comb begin
    redirect_d = (ev == EV_ENTER);
    resume_d   = (ev == EV_RETURN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= SR_RST_CLEAN;
      redirect_q <= 1'b0;
      resume_q   <= 1'b0;
    end else begin
      sr_q       <= sr_d;
      redirect_q <= redirect_d;
      resume_q   <= resume_d;
    end
  end

  assign sr_o        = sr_q;
  assign redirect_o  = redirect_q;
  assign resume_o    = resume_q;
  assign target_pc_o = DBG_HANDLER;
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk #(
  parameter int PC_W      = 32,
  parameter int SR_W      = 16,
  parameter int MODE_LSB  = 0,
  parameter int MODE_W    = 3,
  parameter int DMASK_BIT = 5,
  parameter int DFLAG_BIT = 6,
  parameter logic [MODE_W-1:0] EXC_MODE    = 3'b110,
  parameter logic [PC_W-1:0]   DBG_HANDLER = 32'h8000_0100
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dbg_req_i,
  input logic            dret_i,
  input logic            redirect_o,
  input logic [PC_W-1:0] target_pc_o,
  input logic [SR_W-1:0] sr_o,
  input logic            resume_o,
  input logic [PC_W-1:0] ret_pc_o,
  input logic [SR_W-1:0] ret_sr_o
);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_i && !sr_o[DMASK_BIT] && !sr_o[DFLAG_BIT]) |=>
      (redirect_o && target_pc_o == DBG_HANDLER));

  a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_i && sr_o[DMASK_BIT] && !sr_o[DFLAG_BIT]) |=> !redirect_o);

  a_r4_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (sr_o[DFLAG_BIT] && sr_o[MODE_LSB +: MODE_W] == EXC_MODE));

  a_r6_redirect_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o);

  a_r7_saved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sr_o[DFLAG_BIT] |=> ($stable(ret_pc_o) && $stable(ret_sr_o)));

  a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> (!sr_o[DFLAG_BIT] && sr_o == ret_sr_o));

  a_r10_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o);

  a_r11_stray_return: assert property (@(posedge clk) disable iff (!rst_n)
    (dret_i && !sr_o[DFLAG_BIT]) |=> !resume_o);
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk #(
  .PC_W(PC_W), .SR_W(SR_W), .MODE_LSB(MODE_LSB), .MODE_W(MODE_W),
  .DMASK_BIT(DMASK_BIT), .DFLAG_BIT(DFLAG_BIT), .EXC_MODE(EXC_MODE),
  .DBG_HANDLER(DBG_HANDLER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_req_i(dbg_req_i), .dret_i(dret_i),
  .redirect_o(redirect_o), .target_pc_o(target_pc_o), .sr_o(sr_o),
  .resume_o(resume_o), .ret_pc_o(ret_pc_o), .ret_sr_o(ret_sr_o)
);

// File: tb/dbg_entry_ctrl_test.sv
module dbg_entry_ctrl_test;
  localparam logic [31:0] HANDLER = 32'h8000_0100;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_req_i, sr_wr_i, dret_i;
  logic [31:0] pc_i;
  logic [15:0] sr_wdata_i;
  logic        redirect_o, resume_o;
  logic [31:0] target_pc_o, ret_pc_o;
  logic [15:0] sr_o, ret_sr_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dbg_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dbg_req_i(dbg_req_i), .pc_i(pc_i),
    .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i), .dret_i(dret_i),
    .redirect_o(redirect_o), .target_pc_o(target_pc_o), .sr_o(sr_o),
    .resume_o(resume_o), .ret_pc_o(ret_pc_o), .ret_sr_o(ret_sr_o)
  );

  // {req, dret, wr, wdata[15:0], pc[31:0], exp_redirect, exp_resume, exp_sr[15:0]}
  localparam logic [68:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,16'h0000,32'h0000_0000, 1'b0,1'b0,16'h0001}, // R1 idle
    {1'b1,1'b0,1'b0,16'h0000,32'h1000_0100, 1'b1,1'b0,16'h0046}, // R2 R4 entry
    {1'b1,1'b0,1'b0,16'h0000,32'h2222_0000, 1'b0,1'b0,16'h0046}, // R6 R7 held
    {1'b0,1'b0,1'b1,16'h0003,32'h0000_0000, 1'b0,1'b0,16'h0043}, // R8 mode write
    {1'b0,1'b0,1'b1,16'h00A0,32'h0000_0000, 1'b0,1'b0,16'h00E0}, // R8 flag kept
    {1'b0,1'b1,1'b0,16'h0000,32'h0000_0000, 1'b0,1'b1,16'h0001}, // R10 return
    {1'b0,1'b0,1'b0,16'h0000,32'h0000_0000, 1'b0,1'b0,16'h0001}, // R10 pulse end
    {1'b0,1'b1,1'b0,16'h0000,32'h0000_0000, 1'b0,1'b0,16'h0001}, // R11 stray
    {1'b0,1'b0,1'b1,16'h0020,32'h0000_0000, 1'b0,1'b0,16'h0020}, // R9 privileged
    {1'b1,1'b0,1'b0,16'h0000,32'h3333_0000, 1'b0,1'b0,16'h0020}, // R3 masked
    {1'b0,1'b0,1'b1,16'h0005,32'h0000_0000, 1'b0,1'b0,16'h0000}, // R9 user
    {1'b1,1'b0,1'b1,16'h0F00,32'h4444_0008, 1'b1,1'b0,16'h0046}, // R12 entry wins
    {1'b1,1'b1,1'b1,16'h0001,32'h0000_0000, 1'b0,1'b1,16'h0000}, // R12 return wins
    {1'b0,1'b0,1'b0,16'h0000,32'h0000_0000, 1'b0,1'b0,16'h0000}  // R12 settle
  };
  string tags [NV] = '{"R1","R2","R6","R8","R8","R10","R10","R11",
                       "R9","R3","R9","R12","R12","R12"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic req, input logic ret, input logic wr,
                      input logic [15:0] wd, input logic [31:0] pc);
    dbg_req_i = req; dret_i = ret; sr_wr_i = wr; sr_wdata_i = wd; pc_i = pc;
    @(posedge clk);
    @(negedge clk);
    dbg_req_i = 1'b0; dret_i = 1'b0; sr_wr_i = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; dbg_req_i = 1'b0; dret_i = 1'b0; sr_wr_i = 1'b0;
    sr_wdata_i = '0; pc_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sr", 32'(sr_o), 32'h0001);
    chk("R1 strobes", {30'd0, redirect_o, resume_o}, 32'd0);
    chk("R1 ret_pc", ret_pc_o, 32'd0);
    chk("R1 ret_sr", 32'(ret_sr_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][68], VEC[i][67], VEC[i][66], VEC[i][65:50], VEC[i][49:18]);
      chk({tags[i], " redirect"}, 32'(redirect_o), 32'(VEC[i][17]));
      chk({tags[i], " resume"},   32'(resume_o),   32'(VEC[i][16]));
      chk({tags[i], " sr"},       32'(sr_o),       32'(VEC[i][15:0]));
      if (VEC[i][17]) chk({tags[i], " target"}, target_pc_o, HANDLER);
    end

    // R5 capture from the coincident-strobe entry
    chk("R5 ret_pc", ret_pc_o, 32'h4444_0008);
    chk("R5 ret_sr", 32'(ret_sr_o), 32'h0000);

    // Fresh reset, then capture and hold
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    step(1'b1, 1'b0, 1'b0, 16'h0, 32'hABCD_0010);
    chk("R5 ret_pc new", ret_pc_o, 32'hABCD_0010);
    chk("R5 ret_sr new", 32'(ret_sr_o), 32'h0001);
    step(1'b1, 1'b0, 1'b0, 16'h0, 32'h5555_5555);
    chk("R7 no redirect", 32'(redirect_o), 32'd0);
    chk("R7 ret_pc kept", ret_pc_o, 32'hABCD_0010);
    chk("R7 ret_sr kept", 32'(ret_sr_o), 32'h0001);

    // R1 reset while in debug
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 sr after debug", 32'(sr_o), 32'h0001);
    chk("R1 ret_pc cleared", ret_pc_o, 32'd0);
    chk("R1 ret_sr cleared", 32'(ret_sr_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule